// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block executes one group of 128-bit packed integer instructions: add and subtract over lanes of 8, 16, 32 or 64 bits, and a full-width 128-bit form in which the carry or borrow runs from the lower 64-bit half into the upper one. It owns a 32-entry register file of 128-bit vectors. When an instruction word arrives with its valid strobe, the unit decodes the word, reads both source registers combinationally, forms the result and writes it to the destination register on that same clock edge. The same edge also presents the result on a registered result port.

Execution depends on a vector-enable configuration input. A recognised instruction arriving while that input is low raises a disabled flag and changes nothing. A word that carries the group's major opcode but matches none of the ten encodings raises an illegal flag and also changes nothing. A separate fill port shares the register file's single write port so that operands can be loaded. Fill writes are taken only in cycles with no instruction strobe.

Top module: `simd_addsub_unit`

## Requirements
- R1: After a synchronous active-low reset, every vector register holds zero and res_valid, err_illegal and err_disabled are low.
- R2: Register fields are destination = word[4:0], first source = word[9:5], second source = word[14:10], and the operation is dst = src1 op src2. For an executed instruction, the result is written to dst on the clock edge that samples the strobe. On that edge res_valid goes high for one cycle, with res_dest = dst and res_data = the result.
- R3: Add with word[31:28] = 0111 and word[27:15] = 00000000 followed by 10100, 10101, 10110 or 10111 adds independent lanes of 8, 16, 32 or 64 bits respectively. Each lane wraps modulo 2^width, and no carry crosses a lane boundary.
- R4: Subtract with word[31:28] = 0111 and word[27:15] = 00000000 followed by 11000, 11001, 11010 or 11011 subtracts independent lanes of 8, 16, 32 or 64 bits respectively, wrapping modulo 2^width with no borrow across lanes.
- R5: word[27:15] = 00010010 followed by 11010 is a 128-bit add, and 00010010 followed by 11011 is a 128-bit subtract. The carry or borrow from bit 63 reaches bit 64.
- R6: A recognised encoding with vec_enable low raises err_disabled for one cycle. It produces no res_valid and leaves the register file unchanged.
- R7: A word with word[31:28] = 0111 that matches none of the ten encodings raises err_illegal for one cycle, regardless of vec_enable. It produces no res_valid and performs no write.
- R8: A word whose word[31:28] is not 0111 raises no flag, produces no result and performs no write.
- R9: A following instruction reads the value written by the previous one. When dst equals a source, the operation uses the old source value.
- R10: With insn_valid low and fill_en high, fill_data is written to register fill_addr and no result is reported. When insn_valid is high, the fill request is ignored.
- R11: With insn_valid low, the instruction word has no effect on the outputs or the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction strobe |
| insn_word | input | 32 | Instruction word |
| vec_enable | input | 1 | Vector unit enable configuration bit |
| fill_en | input | 1 | Register fill request |
| fill_addr | input | 5 | Register to fill |
| fill_data | input | 128 | Fill value |
| res_valid | output | 1 | Result written this cycle |
| res_dest | output | 5 | Destination register of the result |
| res_data | output | 128 | Result value |
| err_illegal | output | 1 | Unrecognised encoding in the group |
| err_disabled | output | 1 | Recognised encoding while the unit is disabled |

## Verification
Random operands run through all ten encodings and are compared against a lane-by-lane model, so a wrong lane boundary or a wrong add/subtract selection shows up as a mismatch. Directed all-ones-plus-one and zero-minus-one operands in the 64-bit and 128-bit forms separate the carry that crosses the halves from the carry that must stop at them. The same operands in byte lanes expose any carry that leaks between bytes. Random words with the group opcode and a random selector field, together with words outside the group, show whether illegal, disabled and ignored words are told apart. Each of these cases is followed by a readback through an add with a register that stays zero, which confirms that nothing was written. Back-to-back instructions with dst equal to a source, and fills that collide with an instruction, check write ordering and write-port priority.

// File: rtl/simd_pkg.sv
// Shared types and encodings for the packed add/subtract unit.
// Assumes the fixed 32-bit instruction layout described in the brief.
package simd_pkg;

    typedef enum logic [2:0] {
        LANE_8   = 3'd0,
        LANE_16  = 3'd1,
        LANE_32  = 3'd2,
        LANE_64  = 3'd3,
        LANE_128 = 3'd4
    } lane_e;

    typedef struct packed {
        logic       sub;
        lane_e      lane;
        logic [4:0] dst;
        logic [4:0] src_a;
        logic [4:0] src_b;
    } dec_t;

    localparam logic [3:0]  MAJOR_OP  = 4'b0111;
    localparam logic [12:0] SEL_ADD8   = 13'b00000000_10100;
    localparam logic [12:0] SEL_ADD16  = 13'b00000000_10101;
    localparam logic [12:0] SEL_ADD32  = 13'b00000000_10110;
    localparam logic [12:0] SEL_ADD64  = 13'b00000000_10111;
    localparam logic [12:0] SEL_SUB8   = 13'b00000000_11000;
    localparam logic [12:0] SEL_SUB16  = 13'b00000000_11001;
    localparam logic [12:0] SEL_SUB32  = 13'b00000000_11010;
    localparam logic [12:0] SEL_SUB64  = 13'b00000000_11011;
    localparam logic [12:0] SEL_ADD128 = 13'b00010010_11010;
    localparam logic [12:0] SEL_SUB128 = 13'b00010010_11011;

endpackage

// File: rtl/simd_decode.sv
// Instruction decoder: classifies a word as outside the group, a legal
// add/sub variant, or an illegal member of the group, and extracts fields.
// Assumes: purely combinational; the caller qualifies with the valid strobe.
module simd_decode
    import simd_pkg::*;
(
    input  logic [31:0] word,
    output logic        in_group,
    output logic        legal,
    output dec_t        dec
);

    logic match;

    // Select operation and lane width from the selector field.
    always_comb begin
        match    = 1'b1;
        dec.sub  = 1'b0;
        dec.lane = LANE_8;
        unique case (word[27:15])
            SEL_ADD8:   begin dec.sub = 1'b0; dec.lane = LANE_8;   end
            SEL_ADD16:  begin dec.sub = 1'b0; dec.lane = LANE_16;  end
            SEL_ADD32:  begin dec.sub = 1'b0; dec.lane = LANE_32;  end
            SEL_ADD64:  begin dec.sub = 1'b0; dec.lane = LANE_64;  end
            SEL_ADD128: begin dec.sub = 1'b0; dec.lane = LANE_128; end
            SEL_SUB8:   begin dec.sub = 1'b1; dec.lane = LANE_8;   end
            SEL_SUB16:  begin dec.sub = 1'b1; dec.lane = LANE_16;  end
            SEL_SUB32:  begin dec.sub = 1'b1; dec.lane = LANE_32;  end
            SEL_SUB64:  begin dec.sub = 1'b1; dec.lane = LANE_64;  end
            SEL_SUB128: begin dec.sub = 1'b1; dec.lane = LANE_128; end
            default:    match = 1'b0;
        endcase
    end

    // Field extraction at fixed bit positions.
    assign dec.dst   = word[4:0];
    assign dec.src_a = word[9:5];
    assign dec.src_b = word[14:10];

    assign in_group = (word[31:28] == MAJOR_OP);
    assign legal    = in_group & match;

endmodule

// File: rtl/simd_lane_alu.sv
// Lane-configurable adder/subtractor built from SLICE-bit slices.
// The carry into each slice is the previous slice's carry out, unless the
// slice starts a lane; then it is the subtract bit (two's complement).
// Assumes: W is a multiple of SLICE and a lane is a power-of-two slice count.
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int W     = 128,
    parameter int SLICE = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  lane_e        lane,
    output logic [W-1:0] y
);

    localparam int NSL = W / SLICE;

    logic [W-1:0]   b_eff;
    logic [NSL-1:0] co;
    logic [7:0]     lane_mask;

    // Invert the second operand for subtraction.
    assign b_eff     = sub ? ~b : b;
    // Slice-count mask of one lane: slices whose index has these bits clear start a lane.
    assign lane_mask = (8'd1 << lane) - 8'd1;

    for (genvar gi = 0; gi < NSL; gi++) begin : g_slice
        logic cin;
        if (gi == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = ((8'(gi) & lane_mask) == 8'd0) ? sub : co[gi-1];
        end
        assign {co[gi], y[gi*SLICE +: SLICE]} =
            {1'b0, a[gi*SLICE +: SLICE]} + {1'b0, b_eff[gi*SLICE +: SLICE]}
            + (SLICE+1)'(cin);
    end

endmodule

// File: rtl/simd_vregfile.sv
// Vector register file: NREGS entries of W bits, two combinational read
// ports and one synchronous write port; synchronous active-low reset to zero.
module simd_vregfile #(
    parameter int W     = 128,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_a,
    output logic [W-1:0]  rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] mem [NREGS];

    // Storage: clear on reset, otherwise take the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // Checker support: remember the last write to confirm it landed.
    logic          chk_pend;
    logic [AW-1:0] chk_addr;
    logic [W-1:0]  chk_data;

    // Capture each write for the landing check one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pend <= 1'b0;
            chk_addr <= '0;
            chk_data <= '0;
        end else begin
            chk_pend <= wr_en;
            chk_addr <= wr_addr;
            chk_data <= wr_data;
        end
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_pend |-> (mem[chk_addr] == chk_data));

endmodule

// File: rtl/simd_addsub_unit.sv
// Packed SIMD add/subtract unit: decodes one instruction per cycle, reads
// two vector sources, computes lane-wise or 128-bit add/sub and writes the
// destination on the sampling edge. Flags illegal and disabled words.
// Assumes: a shared write port; an instruction strobe outranks a fill request.
module simd_addsub_unit
    import simd_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREGS = 32,
    parameter int SLICE = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [31:0]     insn_word,
    input  logic            vec_enable,
    input  logic            fill_en,
    input  logic [AW-1:0]   fill_addr,
    input  logic [VLEN-1:0] fill_data,
    output logic            res_valid,
    output logic [AW-1:0]   res_dest,
    output logic [VLEN-1:0] res_data,
    output logic            err_illegal,
    output logic            err_disabled
);

    logic            in_group, legal;
    dec_t            dec;
    logic [VLEN-1:0] src_a, src_b, alu_y;
    logic            do_exec, do_fill, flag_ill, flag_dis;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [VLEN-1:0] wr_data;

    simd_decode u_dec (
        .word     (insn_word),
        .in_group (in_group),
        .legal    (legal),
        .dec      (dec)
    );

    simd_vregfile #(.W(VLEN), .NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (dec.src_a[AW-1:0]),
        .rd_data_a (src_a),
        .rd_addr_b (dec.src_b[AW-1:0]),
        .rd_data_b (src_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    simd_lane_alu #(.W(VLEN), .SLICE(SLICE)) u_alu (
        .a    (src_a),
        .b    (src_b),
        .sub  (dec.sub),
        .lane (dec.lane),
        .y    (alu_y)
    );

    // Classify the current cycle's request.
    always_comb begin
        do_exec  = insn_valid & legal & vec_enable;
        flag_dis = insn_valid & legal & ~vec_enable;
        flag_ill = insn_valid & in_group & ~legal;
        do_fill  = fill_en & ~insn_valid;
    end

    // Share the register file write port between results and fills.
    always_comb begin
        wr_en   = do_exec | do_fill;
        wr_addr = do_exec ? dec.dst[AW-1:0] : fill_addr;
        wr_data = do_exec ? alu_y : fill_data;
    end

    // Register the result report and the fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_dest     <= '0;
            res_data     <= '0;
            err_illegal  <= 1'b0;
            err_disabled <= 1'b0;
        end else begin
            res_valid    <= do_exec;
            res_dest     <= dec.dst[AW-1:0];
            res_data     <= alu_y;
            err_illegal  <= flag_ill;
            err_disabled <= flag_dis;
        end
    end

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, err_illegal, err_disabled}));

    assert_result_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(vec_enable) && $past(insn_valid)));

    assert_fault_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_illegal || err_disabled) |-> $past(insn_valid));

    assert_byte_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_exec && dec.lane == LANE_8 && !dec.sub)
            |-> (alu_y[7:0] == 8'(src_a[7:0] + src_b[7:0])));

    assert_quad_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_exec && dec.lane == LANE_128)
            |-> (alu_y == (dec.sub ? src_a - src_b : src_a + src_b)));

endmodule

// File: tb/tb_simd_addsub_unit.sv
`timescale 1ns/1ps
module tb_simd_addsub_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn_word = '0;
    logic         vec_enable = 1'b0;
    logic         fill_en = 1'b0;
    logic [4:0]   fill_addr = '0;
    logic [127:0] fill_data = '0;
    logic         res_valid;
    logic [4:0]   res_dest;
    logic [127:0] res_data;
    logic         err_illegal;
    logic         err_disabled;

    int checks = 0;
    int errors = 0;
    logic [127:0] mdl [32];

    localparam logic [4:0] ZREG  = 5'd31;  // never written: reads as zero
    localparam logic [4:0] PROBE = 5'd29;  // scratch destination for readbacks

    always #2.5 clk = ~clk;

    simd_addsub_unit dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .vec_enable(vec_enable), .fill_en(fill_en), .fill_addr(fill_addr),
        .fill_data(fill_data), .res_valid(res_valid), .res_dest(res_dest),
        .res_data(res_data), .err_illegal(err_illegal), .err_disabled(err_disabled)
    );

    // Selector field of operation k (0-3 add 8..64, 4 add128, 5-8 sub 8..64, 9 sub128).
    function automatic logic [12:0] sel_of(int k);
        case (k)
            0: return 13'b00000000_10100;
            1: return 13'b00000000_10101;
            2: return 13'b00000000_10110;
            3: return 13'b00000000_10111;
            4: return 13'b00010010_11010;
            5: return 13'b00000000_11000;
            6: return 13'b00000000_11001;
            7: return 13'b00000000_11010;
            8: return 13'b00000000_11011;
            default: return 13'b00010010_11011;
        endcase
    endfunction

    function automatic logic [31:0] enc(int k, logic [4:0] d, logic [4:0] j, logic [4:0] v);
        return {4'b0111, sel_of(k), v, j, d};
    endfunction

    // Reference arithmetic: lane by lane with explicit masking.
    function automatic logic [127:0] ref_op(int k, logic [127:0] a, logic [127:0] b);
        int w;
        logic sub;
        logic [128:0] m, x, y, r;
        sub = (k >= 5);
        case (k)
            0, 5: w = 8;
            1, 6: w = 16;
            2, 7: w = 32;
            3, 8: w = 64;
            default: w = 128;
        endcase
        m = (129'd1 << w) - 129'd1;
        r = '0;
        for (int l = 0; l < 128 / w; l++) begin
            x = ({1'b0, a} >> (l * w)) & m;
            y = ({1'b0, b} >> (l * w)) & m;
            r = r | (((sub ? x - y : x + y) & m) << (l * w));
        end
        return r[127:0];
    endfunction

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one instruction for one cycle, then check outputs and update the model.
    task automatic issue(logic [31:0] w, logic en, string tag);
        int k_hit;
        logic grp, exp_v, exp_i, exp_d;
        logic [127:0] exp_r;
        k_hit = -1;
        for (int k = 0; k < 10; k++)
            if (w == enc(k, w[4:0], w[9:5], w[14:10])) k_hit = k;
        grp   = (w[31:28] == 4'b0111);
        exp_v = (k_hit >= 0) && en;
        exp_d = (k_hit >= 0) && !en;
        exp_i = grp && (k_hit < 0);
        exp_r = (k_hit >= 0) ? ref_op(k_hit, mdl[w[9:5]], mdl[w[14:10]]) : '0;
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = w;
        vec_enable = en;
        @(posedge clk);
        #1;
        check({tag, " res_valid"}, 128'(res_valid), 128'(exp_v));
        check({tag, " err_illegal"}, 128'(err_illegal), 128'(exp_i));
        check({tag, " err_disabled"}, 128'(err_disabled), 128'(exp_d));
        if (exp_v) begin
            check({tag, " res_dest"}, 128'(res_dest), 128'(w[4:0]));
            check({tag, " res_data"}, res_data, exp_r);
            mdl[w[4:0]] = exp_r;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        insn_valid = 1'b0;
        fill_en    = 1'b0;
    endtask

    task automatic fill(logic [4:0] a, logic [127:0] d);
        @(negedge clk);
        insn_valid = 1'b0;
        fill_en    = 1'b1;
        fill_addr  = a;
        fill_data  = d;
        @(posedge clk);
        #1;
        check("R10 fill gives no result", 128'(res_valid), 128'b0);
        mdl[a] = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Read a register back through a 128-bit add with the zero register.
    task automatic probe(logic [4:0] r, string tag);
        logic [127:0] exp;
        exp = mdl[r];
        issue(enc(4, PROBE, r, ZREG), 1'b1, {tag, " readback"});
        check({tag, " readback value"}, res_data, exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of outputs and registers
        check("R1 res_valid", 128'(res_valid), 128'b0);
        check("R1 err_illegal", 128'(err_illegal), 128'b0);
        check("R1 err_disabled", 128'(err_disabled), 128'b0);
        probe(5'd3, "R1 reg3");
        probe(5'd17, "R1 reg17");

        // R10: load operands through the fill port
        for (int i = 0; i < 29; i++) fill(5'(i), rnd128());
        probe(5'd7, "R10 fill");

        // R3 R4 R5: directed carry corner cases
        fill(5'd1, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        fill(5'd2, 128'd1);
        issue(enc(4, 5'd5, 5'd1, 5'd2), 1'b1, "R5 add128 carry crosses halves");
        check("R5 add128 value", res_data, {64'd1, 64'd0});
        issue(enc(3, 5'd5, 5'd1, 5'd2), 1'b1, "R3 add64 carry stops at half");
        check("R3 add64 value", res_data, 128'd0);
        issue(enc(9, 5'd5, ZREG, 5'd2), 1'b1, "R5 sub128 borrow crosses halves");
        check("R5 sub128 value", res_data, {128{1'b1}});
        issue(enc(8, 5'd5, ZREG, 5'd2), 1'b1, "R4 sub64 borrow stops at half");
        check("R4 sub64 value", res_data, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        fill(5'd1, {16{8'hFF}});
        fill(5'd2, {16{8'h01}});
        issue(enc(0, 5'd6, 5'd1, 5'd2), 1'b1, "R3 add8 byte wrap");
        check("R3 add8 value", res_data, 128'd0);
        issue(enc(5, 5'd6, ZREG, 5'd2), 1'b1, "R4 sub8 byte borrow");
        check("R4 sub8 value", res_data, {16{8'hFF}});
        issue(enc(1, 5'd6, 5'd1, 5'd2), 1'b1, "R3 add16 lanes");
        issue(enc(7, 5'd6, 5'd1, 5'd2), 1'b1, "R4 sub32 lanes");

        // R9: back-to-back dependency and destination equal to a source
        issue(enc(2, 5'd8, 5'd8, 5'd9), 1'b1, "R9 dst equals src1");
        issue(enc(6, 5'd10, 5'd8, 5'd8), 1'b1, "R9 reads previous result");
        issue(enc(0, 5'd11, 5'd11, 5'd11), 1'b1, "R9 all fields same");

        // R6: disabled unit leaves destination untouched
        issue(enc(2, 5'd12, 5'd13, 5'd14), 1'b0, "R6 disabled");
        probe(5'd12, "R6 dst unchanged");

        // R7: illegal selector, also with the unit disabled
        issue({4'b0111, 13'b00000000_00000, 5'd14, 5'd13, 5'd12}, 1'b1, "R7 illegal");
        probe(5'd12, "R7 dst unchanged");
        issue({4'b0111, 13'b11111111_11111, 5'd14, 5'd13, 5'd12}, 1'b0, "R7 illegal disabled");
        probe(5'd12, "R7 dst unchanged when disabled");

        // R8: outside the group
        issue({4'b0110, SEL_ADD, 5'd14, 5'd13, 5'd12}, 1'b1, "R8 other group");
        probe(5'd12, "R8 dst unchanged");

        // R11: strobe low, word ignored
        idle();
        insn_word  = enc(0, 5'd12, 5'd13, 5'd14);
        vec_enable = 1'b1;
        @(posedge clk);
        #1;
        check("R11 no result", 128'(res_valid), 128'b0);
        check("R11 no flag", 128'(err_illegal | err_disabled), 128'b0);
        probe(5'd12, "R11 dst unchanged");

        // R10: fill request during an instruction is dropped
        @(negedge clk);
        fill_en   = 1'b1;
        fill_addr = 5'd20;
        fill_data = ~mdl[20];
        issue(enc(1, 5'd21, 5'd22, 5'd23), 1'b1, "R10 insn wins");
        idle();
        probe(5'd20, "R10 colliding fill ignored");

        // R2 R3 R4 R5 R6 R7 R8: constrained random mix
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [31:0] w;
            kind = int'($urandom_range(0, 99));
            if (kind < 70)
                w = enc(int'($urandom_range(0, 9)), 5'($urandom_range(0, 28)),
                        5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
            else if (kind < 85)
                w = {4'b0111, 13'($urandom()), 5'($urandom_range(0, 28)), 10'($urandom())};
            else
                w = $urandom();
            if (w[4:0] == ZREG) w[4:0] = 5'd0;
            issue(w, ($urandom_range(0, 9) != 0), "R2 random");
            if (n % 50 == 0) fill(5'($urandom_range(0, 28)), rnd128());
        end
        idle();
        for (int r = 0; r < 29; r++) probe(5'(r), "R2 final state");
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [12:0] SEL_ADD = 13'b00000000_10100;

endmodule